// File: doc/BRIEF.md
# Time-Varying Gain SPI Sequencer

After every transmit pulse this block walks a small table of (time offset, gain code) pairs. Each time the elapsed time since the pulse reaches an entry's offset, it sends that entry's gain code to a variable-gain amplifier as one SPI write. The gain therefore rises along the loss curve of the returning echo across one acquisition window. The curve itself is computed elsewhere and loaded through a simple write port. Gain is coded in half-decibel steps from 0 to 40 dB. Writes to the amplifier are kept a minimum interval apart; an entry that falls due too early is delayed until that interval has passed, and it is never skipped.

When the time-varying gain is switched off, the block holds the amplifier at a fixed mid-range gain, so that noise and channel-matching measurements run at a known setting. Every transmit pulse restarts the schedule from its first entry.

Top module: `tvg_spi_sequencer`

## Requirements
- R1: The gain code is the gain in dB times two (0.5 dB per step, 0 to 80). A table code above MAX_CODE (80) is sent as 80.
- R2: Each write is a 16-bit frame sent MSB first. Bits 15:8 hold FRAME_HDR (0x5A), bit 7 is 0 and bits 6:0 hold the gain code. SPI mode 0 is used: SCLK idles low, the receiver samples MOSI on the rising edge and MOSI changes only while SCLK is low. spi_cs_n stays low across all 16 bits.
- R3: With enable high, a tx_start pulse sampled on clock edge E starts the schedule. An entry with offset T µs (T nonzero), when not delayed, drops spi_cs_n on edge E + T*CLK_MHZ + 1.
- R4: Entries are sent in table order starting at entry 0. The schedule ends at the first entry whose offset is zero, or after the last of the 64 entries. Entries after a zero offset are never sent.
- R5: Two falling edges of spi_cs_n are at least MIN_GAP_US*CLK_MHZ clocks (2 µs) apart. An entry that becomes due sooner waits, and it is sent on exactly the edge at which that interval ends.
- R6: A tx_start pulse while a schedule is running restarts it at entry 0 with the elapsed time cleared.
- R7: While enable is low, tx_start is ignored and the block writes HOLD_CODE (40, which is 20 dB) once. This happens after reset or when enable falls, and no other frame follows.
- R8: busy is high from an accepted tx_start until the schedule has ended and the last frame has finished, and low otherwise.
- R9: During reset spi_cs_n is high, spi_sclk is low and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Time-varying gain on; when low, the amplifier is held at HOLD_CODE |
| tx_start | input | 1 | One-cycle pulse marking a transmit event |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table entry index |
| wr_time | input | 16 | Entry offset in µs after tx_start (0 ends the table) |
| wr_gain | input | 7 | Entry gain code |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the amplifier |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Schedule or frame in progress |

## Verification
The in-module assertions check the following on every cycle: the minimum spacing between chip-select falls, SCLK held low while deselected, MOSI steady while SCLK is high, the code range of each loaded frame, the hold code whenever enable was low, and busy covering each frame. Only the bench scenarios can show which entries are sent, their exact launch cycles against the table, the stop at a zero offset, the restart on a second pulse and the silence after the hold write. The bench does this by decoding the SPI frames and comparing them with its own walk of the table.

// File: rtl/tvg_spi_sequencer.sv
`timescale 1ns/1ps
module tvg_spi_sequencer #(
  parameter int          CLK_MHZ    = 100,
  parameter int          DEPTH      = 64,
  parameter int          TW         = 16,
  parameter int          GW         = 7,
  parameter int          MAX_CODE   = 80,
  parameter int          HOLD_CODE  = 40,
  parameter int          MIN_GAP_US = 2,
  parameter int          SCLK_HALF  = 4,
  parameter logic [7:0]  FRAME_HDR  = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     tx_start,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [TW-1:0]            wr_time,
  input  logic [GW-1:0]            wr_gain,
  output logic                     spi_sclk,
  output logic                     spi_mosi,
  output logic                     spi_cs_n,
  output logic                     busy
);
  localparam int AW      = $clog2(DEPTH);
  localparam int IW      = AW + 1;
  localparam int FW      = 16;
  localparam int GAP_CYC = MIN_GAP_US * CLK_MHZ;
  localparam int GCW     = $clog2(GAP_CYC + 1);
  localparam int DIVW    = $clog2(CLK_MHZ + 1);
  localparam int HDW     = $clog2(SCLK_HALF + 1);
  localparam int HPW     = $clog2(2 * FW + 1);

  logic [TW-1:0]  tbl_time [DEPTH];
  logic [GW-1:0]  tbl_gain [DEPTH];
  logic [DIVW-1:0] us_div;
  logic [TW-1:0]  elapsed;
  logic           running;
  logic [IW-1:0]  idx;
  logic [GCW-1:0] gap_cnt;
  logic [GW-1:0]  applied;
  logic           applied_vld;
  logic           act;
  logic [HPW-1:0] hp;
  logic [HDW-1:0] hdiv;
  logic [FW-1:0]  sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl_time[i] <= '0;
        tbl_gain[i] <= '0;
      end
    end else if (wr_en) begin
      tbl_time[wr_addr] <= wr_time;
      tbl_gain[wr_addr] <= wr_gain;
    end
  end

  wire            at_end   = (idx == IW'(DEPTH));
  wire [AW-1:0]   cur      = idx[AW-1:0];
  wire            term     = at_end || (tbl_time[cur] == '0);
  wire            due      = running && !term && (elapsed >= tbl_time[cur]);
  wire            gap_ok   = (gap_cnt == '0);
  wire            l_sched  = enable && due && gap_ok && !act;
  wire            l_hold   = !enable && (!applied_vld || applied != GW'(HOLD_CODE)) && gap_ok && !act;
  wire            launch   = l_sched || l_hold;
  wire [GW-1:0]   code_raw = l_hold ? GW'(HOLD_CODE) : tbl_gain[cur];
  wire [GW-1:0]   code     = (code_raw > GW'(MAX_CODE)) ? GW'(MAX_CODE) : code_raw;
  wire [FW-1:0]   frame    = {FRAME_HDR, {(8-GW){1'b0}}, code};

  always_ff @(posedge clk) begin
    if (!rst_n || tx_start) begin
      us_div  <= '0;
      elapsed <= '0;
    end else if (us_div == DIVW'(CLK_MHZ - 1)) begin
      us_div  <= '0;
      if (elapsed != '1) elapsed <= elapsed + 1'b1;
    end else begin
      us_div <= us_div + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (tx_start) begin
      running <= enable;
      idx     <= '0;
    end else if (!enable || (running && term)) begin
      running <= 1'b0;
    end else if (l_sched) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt     <= '0;
      applied     <= '0;
      applied_vld <= 1'b0;
    end else if (launch) begin
      gap_cnt     <= GCW'(GAP_CYC - 1);
      applied     <= code;
      applied_vld <= 1'b1;
    end else if (!gap_ok) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      hp   <= '0;
      hdiv <= '0;
      sh   <= '0;
    end else if (launch) begin
      act  <= 1'b1;
      hp   <= '0;
      hdiv <= '0;
      sh   <= frame;
    end else if (act) begin
      if (hdiv == HDW'(SCLK_HALF - 1)) begin
        hdiv <= '0;
        if (hp == HPW'(2 * FW)) act <= 1'b0;
        else begin
          hp <= hp + 1'b1;
          if (hp[0]) sh <= sh << 1;
        end
      end else begin
        hdiv <= hdiv + 1'b1;
      end
    end
  end

  assign spi_sclk = act & hp[0];
  assign spi_mosi = sh[FW-1];
  assign spi_cs_n = ~act;
  assign busy     = running | act;

  logic        cs_d;
  logic [15:0] mon_gap;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_d    <= 1'b1;
      mon_gap <= 16'(GAP_CYC);
    end else begin
      cs_d    <= spi_cs_n;
      mon_gap <= (cs_d && !spi_cs_n) ? 16'd1 : ((mon_gap == 16'hFFFF) ? mon_gap : mon_gap + 1'b1);
    end
  end

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !spi_cs_n) |-> (mon_gap >= 16'(GAP_CYC))); // R5
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R2
  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R2
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (sh[GW-1:0] <= GW'(MAX_CODE))); // R1
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && !$past(enable)) |-> (sh[GW-1:0] == GW'(HOLD_CODE))); // R7
  AST_BUSY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R8
endmodule

// File: tb/tvg_spi_sequencer_test.sv
`timescale 1ns/1ps
module tvg_spi_sequencer_test;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, tx_start = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [15:0] wr_time = '0;
  logic [6:0] wr_gain = '0;
  logic spi_sclk, spi_mosi, spi_cs_n, busy;
  always #5 clk = ~clk;

  tvg_spi_sequencer uut (.clk(clk), .rst_n(rst_n), .enable(enable), .tx_start(tx_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_time(wr_time), .wr_gain(wr_gain),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy));

  localparam logic [22:0] VEC [7] = '{
    {16'd5, 7'd10}, {16'd10, 7'd30}, {16'd11, 7'd50}, {16'd11, 7'd60},
    {16'd20, 7'd100}, {16'd0, 7'd0}, {16'd30, 7'd7}};

  int checks = 0, fails = 0;
  int mt [64];
  int mg [64];
  logic [15:0] fr_val [256];
  longint fr_fall [256];
  int fr_bits [256];
  int nfr = 0, bitc = 0, mode_bad = 0;
  logic [15:0] shin = '0;
  longint fall_t = 0;

  always @(posedge spi_sclk) begin
    if (spi_cs_n) mode_bad++;
    shin = {shin[14:0], spi_mosi};
    bitc++;
  end
  always @(negedge spi_cs_n) begin
    if (spi_sclk) mode_bad++;
    fall_t = $time; bitc = 0;
  end
  always @(posedge spi_cs_n) begin
    if (nfr < 256) begin
      fr_val[nfr] = shin; fr_fall[nfr] = fall_t; fr_bits[nfr] = bitc; nfr++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int t, input int g);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_time = 16'(t); wr_gain = 7'(g);
    mt[a] = t; mg[a] = g;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(output longint t);
    @(negedge clk);
    tx_start = 1'b1; t = $time + 5;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Walk the bench copy of the table and compare with decoded frames from index base.
  task automatic expect_sched(input longint txt, input int base, output int n);
    longint prev, due, st;
    int c;
    prev = (base > 0) ? fr_fall[base-1] : -100000;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (mt[i] == 0) break;
      due = txt + (longint'(mt[i]) * 100 + 1) * 10;
      st = (due > prev + 2000) ? due : prev + 2000;
      c = (mg[i] > 80) ? 80 : mg[i];
      if (base + n < nfr) begin
        if (st > due) chk(fr_fall[base+n] == st, "R5 postponed launch time", fr_fall[base+n], st);
        else chk(fr_fall[base+n] == st, "R3 launch time", fr_fall[base+n], st);
        if (mg[i] > 80) chk(fr_val[base+n] == {8'h5A, 1'b0, 7'(c)}, "R1 clamped frame", fr_val[base+n], {8'h5A, 1'b0, 7'(c)});
        else chk(fr_val[base+n] == {8'h5A, 1'b0, 7'(c)}, "R2 frame value", fr_val[base+n], {8'h5A, 1'b0, 7'(c)});
        chk(fr_bits[base+n] == 16, "R2 bits per frame", fr_bits[base+n], 16);
      end
      prev = st;
      n++;
    end
  endtask

  bit done = 0;
  initial begin
    #5_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint t1, t2;
    int n, b, k;
    for (int i = 0; i < 64; i++) begin mt[i] = 0; mg[i] = 0; end
    idle(4);
    chk(spi_cs_n === 1'b1, "R9 cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b0, "R9 sclk in reset", spi_sclk, 0);
    chk(busy === 1'b0, "R9 busy in reset", busy, 0);
    rst_n = 1'b1;
    idle(400);
    chk(nfr == 1, "R7 one hold frame after reset", nfr, 1);
    chk(fr_val[0] == 16'h5A28, "R7 hold frame value", fr_val[0], 16'h5A28);

    for (int i = 0; i < 7; i++) wr(i, int'(VEC[i][22:7]), int'(VEC[i][6:0]));
    enable = 1'b1;
    idle(300);
    chk(nfr == 1, "R7 no frame on enable rise", nfr, 1);

    // Scenario: main schedule with postponement, clamp and terminator
    b = nfr;
    pulse(t1);
    idle(1500);
    chk(busy === 1'b1, "R8 busy during schedule", busy, 1);
    idle(2500);
    chk(busy === 1'b0, "R8 busy cleared after schedule", busy, 0);
    expect_sched(t1, b, n);
    chk(nfr - b == n, "R4 frame count stops at zero offset", nfr - b, n);

    // Scenario: restart while running
    b = nfr;
    pulse(t1);
    idle(698);
    pulse(t2);
    idle(4000);
    chk(fr_val[b] == 16'h5A0A, "R6 frame before restart", fr_val[b], 16'h5A0A);
    expect_sched(t2, b + 1, n);
    chk(nfr - b == n + 1, "R6 restarted schedule count", nfr - b, n + 1);

    // Scenario: disable mid-schedule, then ignored pulse
    b = nfr;
    pulse(t1);
    idle(800);
    enable = 1'b0;
    idle(3000);
    chk(nfr - b == 2, "R7 one hold frame after disable", nfr - b, 2);
    chk(fr_val[b+1] == 16'h5A28, "R7 hold code after disable", fr_val[b+1], 16'h5A28);
    b = nfr;
    pulse(t1);
    idle(5);
    chk(busy === 1'b0, "R7 pulse ignored busy", busy, 0);
    idle(3000);
    chk(nfr == b, "R7 pulse ignored no frames", nfr - b, 0);

    // Scenario: every entry used
    enable = 1'b1;
    for (int i = 0; i < 64; i++) wr(i, 1 + 3 * i, i);
    b = nfr;
    pulse(t1);
    idle(20000);
    expect_sched(t1, b, n);
    chk(nfr - b == 64, "R4 all 64 entries sent", nfr - b, 64);
    k = nfr - 1;
    chk(fr_val[k] == 16'h5A3F, "R4 last entry", fr_val[k], 16'h5A3F);
    chk(busy === 1'b0, "R8 busy low after full table", busy, 0);

    chk(mode_bad == 0, "R2 mode 0 edges", mode_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule